// File: doc/BRIEF.md
# Fifteen-Pin General-Purpose I/O Port with Shared-Pin Readback

The block is a general-purpose I/O port of fifteen pins, programmed over a small register interface. There are three registers. The function register gives each pin either to this port or to a host-interface function outside the block. The direction register makes a port-owned pin an input (0) or an output (1). The data register holds the value that an output pin drives.

When a pin belongs to the host-interface function, that function's own output value and output enable go to the pad. The port's registers do not drive it. The direction bit of that pin still picks what a read of the data register returns. With direction 1 the read returns the stored data bit. With direction 0 it returns the live pin level, whoever is driving the pin. This lets software watch host-interface traffic on a pin, or use the data register as scratch storage.

Pin levels pass through a two-stage synchronizer before any readback uses them. Read data is registered.

Top module: `gpio_port`

## Requirements
- R1: A synchronous, active-high reset clears the function, direction and data registers and `rdata` to zero. After reset, every pin is a port-owned input with `pin_oe` = 0 and `pin_out` = 0.
- R2: When `we` is high at a clock edge, `wdata` is written to one register chosen by `addr`: 0 = function, 1 = direction, 2 = data. A write to address 3 changes no register. A read of address 0 or 1 returns the stored function or direction register.
- R3: For a pin whose function bit is 0, `pin_oe` equals its direction bit and `pin_out` equals its data bit. Both take a new register value in the cycle after the write edge.
- R4: For a pin whose function bit is 1, `pin_oe` and `pin_out` follow `host_oe` and `host_out` combinationally, whatever the direction and data bits hold.
- R5: A read of address 2 returns, for each pin with direction bit 0, the level of `pin_in` after two synchronizer flops. A change applied before edge k is returned by a read whose enable is sampled at edge k+2, and not by one sampled at edge k or k+1. This holds for pins with function bit 0 and with function bit 1.
- R6: A read of address 2 returns the stored data bit for each pin with direction bit 1, in either function mode.
- R7: `rdata` is loaded at the edge where `re` is high and is visible from the next cycle. It holds its value while `re` is low. A read of address 3 returns 0.
- R8: A write to the data register of a port-owned input pin (function 0, direction 0) leaves `pin_oe` at 0. The bit is still stored and can be read back once the pin's direction is set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select: 0 function, 1 direction, 2 data, 3 unused |
| we | input | 1 | Write enable |
| re | input | 1 | Read enable |
| wdata | input | 15 | Write data, bit i for pin i |
| rdata | output | 15 | Registered read data |
| host_out | input | 15 | Output values from the host-interface function |
| host_oe | input | 15 | Output enables from the host-interface function |
| pin_in | input | 15 | Pad input levels |
| pin_out | output | 15 | Pad output values |
| pin_oe | output | 15 | Pad output enables |

## Verification
A bad function bit shows at once on `pin_oe` and `pin_out`, because those outputs then follow the host pair instead of the registers, or the other way round. A bad direction or data bit shows on the pad outputs of a port-owned pin in the cycle after the write. On a host-owned pin it shows only through readback: the next data-register read returns the pin level where the stored bit was expected, or the stored bit where the pin level was expected. A synchronizer of the wrong depth shifts by one read the point at which a pin change first appears in `rdata`. Back-to-back reads after a pin change expose that directly.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int GPIO_PINS  = 15;
    localparam int SYNC_DEPTH = 2;
    localparam int ADDR_W     = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_FUNC = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    function automatic logic pick_view(input logic dir_bit,
                                       input logic stored_bit,
                                       input logic level_bit);
        return dir_bit ? stored_bit : level_bit;
    endfunction

    function automatic logic pick_drive(input logic func_bit,
                                        input logic host_bit,
                                        input logic local_bit);
        return func_bit ? host_bit : local_bit;
    endfunction

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int N = GPIO_PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    output logic [N-1:0]      func_q,
    output logic [N-1:0]      dir_q,
    output logic [N-1:0]      data_q
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            func_q <= '0;
            dir_q  <= '0;
            data_q <= '0;
        end else if (we) begin
            case (sel)
                SEL_FUNC: func_q <= wdata;
                SEL_DIR:  dir_q  <= wdata;
                SEL_DATA: data_q <= wdata;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_pkg::*;
#(
    parameter int N      = GPIO_PINS,
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    logic [N-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
    import gpio_pkg::*;
#(
    parameter int N = GPIO_PINS
) (
    input  logic [N-1:0] func_q,
    input  logic [N-1:0] dir_q,
    input  logic [N-1:0] data_q,
    input  logic [N-1:0] host_out,
    input  logic [N-1:0] host_oe,
    input  logic [N-1:0] level_sync,
    output logic [N-1:0] pin_out,
    output logic [N-1:0] pin_oe,
    output logic [N-1:0] data_view
);

    for (genvar g = 0; g < N; g++) begin : g_pin
        // Pad drive: the host function or the port registers
        assign pin_oe[g]    = pick_drive(func_q[g], host_oe[g],  dir_q[g]);
        assign pin_out[g]   = pick_drive(func_q[g], host_out[g], data_q[g]);
        // Readback: the direction bit decides in both function modes
        assign data_view[g] = pick_view(dir_q[g], data_q[g], level_sync[g]);
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int N = GPIO_PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    input  logic [N-1:0]      wdata,
    output logic [N-1:0]      rdata,
    input  logic [N-1:0]      host_out,
    input  logic [N-1:0]      host_oe,
    input  logic [N-1:0]      pin_in,
    output logic [N-1:0]      pin_out,
    output logic [N-1:0]      pin_oe
);

    logic [N-1:0] func_q, dir_q, data_q;
    logic [N-1:0] level_sync, data_view;

    gpio_regfile #(.N(N)) u_regs (
        .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
        .func_q(func_q), .dir_q(dir_q), .data_q(data_q)
    );

    gpio_sync #(.N(N), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .din(pin_in), .dout(level_sync)
    );

    gpio_pinmux #(.N(N)) u_mux (
        .func_q(func_q), .dir_q(dir_q), .data_q(data_q),
        .host_out(host_out), .host_oe(host_oe), .level_sync(level_sync),
        .pin_out(pin_out), .pin_oe(pin_oe), .data_view(data_view)
    );

    reg_sel_e rsel;
    assign rsel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            case (rsel)
                SEL_FUNC: rdata <= func_q;
                SEL_DIR:  rdata <= dir_q;
                SEL_DATA: rdata <= data_view;
                default:  rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int N = GPIO_PINS
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              we,
    input logic              re,
    input logic [N-1:0]      wdata,
    input logic [N-1:0]      rdata,
    input logic [N-1:0]      pin_out,
    input logic [N-1:0]      pin_oe,
    input logic [N-1:0]      func_q,
    input logic [N-1:0]      dir_q,
    input logic [N-1:0]      data_q
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && rdata == '0 && func_q == '0));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == SEL_DIR) |=> dir_q == $past(wdata));

    // R2
    none_write_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == SEL_NONE) |=>
            (func_q == $past(func_q) && dir_q == $past(dir_q) && data_q == $past(data_q)));

    // R3
    gpio_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == SEL_DATA) |=> ((pin_out ^ $past(wdata)) & ~func_q) == '0);

    // R6
    stored_view_chk: assert property (@(posedge clk) disable iff (rst)
        (re && addr == SEL_DATA) |=> ((rdata ^ $past(data_q)) & $past(dir_q)) == '0);

    // R7
    hold_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        !re |=> $stable(rdata));

    // R7
    none_read_chk: assert property (@(posedge clk) disable iff (rst)
        (re && addr == SEL_NONE) |=> rdata == '0);

endmodule

bind gpio_port gpio_port_chk #(.N(N)) u_chk (
    .clk(clk), .rst(rst), .addr(addr), .we(we), .re(re), .wdata(wdata),
    .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe),
    .func_q(func_q), .dir_q(dir_q), .data_q(data_q)
);

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;

    localparam int N = 15;
    localparam logic [N-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   addr;
    logic         we, re;
    logic [N-1:0] wdata, rdata, host_out, host_oe, pin_in, pin_out, pin_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gpio_port i_gpio_port (
        .clk(clk), .rst(rst), .addr(addr), .we(we), .re(re),
        .wdata(wdata), .rdata(rdata), .host_out(host_out), .host_oe(host_oe),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    typedef struct packed {
        logic [N-1:0] func;
        logic [N-1:0] dir;
        logic [N-1:0] data;
        logic [N-1:0] pin;
        logic [N-1:0] hoe;
        logic [N-1:0] hout;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{15'h0000, 15'h7FFF, 15'h2AAA, 15'h5555, 15'h7FFF, 15'h7FFF},
        '{15'h0000, 15'h0000, 15'h7FFF, 15'h1234, 15'h7FFF, 15'h0F0F},
        '{15'h0000, 15'h00FF, 15'h0F0F, 15'h7070, 15'h0000, 15'h0000},
        '{15'h7FFF, 15'h0000, 15'h3C3C, 15'h4321, 15'h5A5A, 15'h2525},
        '{15'h7FFF, 15'h7FFF, 15'h6666, 15'h1111, 15'h0F00, 15'h00F0},
        '{15'h5555, 15'h3333, 15'h0F0F, 15'h7E81, 15'h1248, 15'h7BDE}
    };

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
        @(negedge clk);
        addr = a; re = 1'b1;
        @(negedge clk);
        re = 1'b0;
        d = rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] r, exp_view;
        rst = 1'b1; addr = '0; we = 1'b0; re = 1'b0; wdata = '0;
        host_out = ONES; host_oe = ONES; pin_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 pin_oe", pin_oe, '0);
        chk("R1 pin_out", pin_out, '0);
        chk("R1 rdata", rdata, '0);
        rd(2'd0, r); chk("R1 func", r, '0);
        rd(2'd1, r); chk("R1 dir", r, '0);

        // vector walk: R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            wr(2'd0, VECS[v].func);
            wr(2'd1, VECS[v].dir);
            wr(2'd2, VECS[v].data);
            pin_in   = VECS[v].pin;
            host_oe  = VECS[v].hoe;
            host_out = VECS[v].hout;
            @(negedge clk); @(negedge clk);
            #1;
            chk("R3 R4 pin_oe", pin_oe,
                (VECS[v].func & VECS[v].hoe) | (~VECS[v].func & VECS[v].dir));
            chk("R3 R4 pin_out", pin_out,
                (VECS[v].func & VECS[v].hout) | (~VECS[v].func & VECS[v].data));
            exp_view = (VECS[v].dir & VECS[v].data) | (~VECS[v].dir & VECS[v].pin);
            rd(2'd2, r); chk("R5 R6 data view", r, exp_view);
            rd(2'd0, r); chk("R2 func readback", r, VECS[v].func);
            rd(2'd1, r); chk("R2 dir readback", r, VECS[v].dir);
        end

        // R4: host pair change without any register write
        wr(2'd0, ONES);
        @(negedge clk);
        host_oe = 15'h0421; host_out = 15'h7001;
        #1;
        chk("R4 live host_oe", pin_oe, 15'h0421);
        chk("R4 live host_out", pin_out, 15'h7001);

        // R2: write to address 3 changes nothing
        wr(2'd0, 15'h0003);
        wr(2'd1, 15'h0005);
        wr(2'd3, ONES);
        rd(2'd0, r); chk("R2 addr3 func", r, 15'h0003);
        rd(2'd1, r); chk("R2 addr3 dir", r, 15'h0005);

        // R7: address 3 reads zero, rdata holds without re
        rd(2'd3, r); chk("R7 addr3 read", r, '0);
        rd(2'd1, r);
        @(negedge clk);
        addr = 2'd0;
        @(negedge clk); @(negedge clk);
        chk("R7 hold", rdata, 15'h0005);

        // R8: data write to a GPIO input pin
        wr(2'd0, '0);
        wr(2'd1, '0);
        wr(2'd2, 15'h5A5A);
        #1;
        chk("R8 oe stays low", pin_oe, '0);
        wr(2'd1, ONES);
        rd(2'd2, r); chk("R8 stored bit", r, 15'h5A5A);

        // R5: synchronizer latency with back-to-back reads, GPIO inputs
        wr(2'd1, '0);
        pin_in = '0;
        repeat (3) @(negedge clk);
        addr = 2'd2; re = 1'b1; pin_in = 15'h6DB6;
        @(negedge clk); chk("R5 edge k", rdata, '0);
        @(negedge clk); chk("R5 edge k+1", rdata, '0);
        @(negedge clk); chk("R5 edge k+2", rdata, 15'h6DB6);
        re = 1'b0;

        // R5: host-owned pin with direction 0 shows the pin level
        wr(2'd0, ONES);
        pin_in = 15'h0C30;
        @(negedge clk); @(negedge clk);
        rd(2'd2, r); chk("R5 host pin level", r, 15'h0C30);

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 re-reset oe", pin_oe, '0);
        chk("R1 re-reset rdata", rdata, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule